// File: doc/BRIEF.md
# Ten-Pin GPIO Register Bank

This block controls ten general-purpose pins through four 16-bit registers on a simple indexed register bus. The registers set pin direction, polarity or drive type, and sticky enable, and they hold the pin status. Each pin input passes through a two-flop synchroniser. The synchronised input is then corrected for polarity. It either flows straight into the status register or, for sticky pins, sets a latched event bit on a chosen edge. Software clears a latched bit by writing zero to it.

The same polarity bit has a second meaning on output pins: it selects push-pull or open-drain drive. For an output pin, the value written to the status register is the value driven. The ten conditioned input bits also leave the block on a parallel port, where a separate serial-frame formatter picks them up. The bus does a write in one clock, and a read comes back combinationally on the addressed register.

Top module: `gpio_bank`

## Requirements
- R1: The direction register at index 4Ch resets to 03FFh. A 1 in bit i makes pin i an input and a 0 makes it an output. Bits 15..10 always read back as 0.
- R2: A one-cycle pulse on `modem_rst` returns every register to its reset value: direction 03FFh, polarity FFFFh, sticky 0000h and status 0000h.
- R3: The polarity/type register at index 4Eh resets to FFFFh. Bits 15..10 always read back as 1.
- R4: An output pin whose polarity bit is 0 uses push-pull drive. `pin_oe` is 1 and `pin_out` equals the bit last written to the status register at index 54h.
- R5: An output pin whose polarity bit is 1 uses open-drain drive. A written 1 gives `pin_oe` = 0, so the pin is released. A written 0 gives `pin_oe` = 1 and `pin_out` = 0.
- R6: For a non-sticky input, status bit i equals the synchronised pin level when polarity bit i is 1, and its inverse when polarity bit i is 0. A pin change shows in status three clock edges later. Bus writes to that bit have no effect.
- R7: For an input whose bit is set in the sticky register at index 50h, a rising edge sets status bit i when polarity bit i is 1, and a falling edge sets it when polarity bit i is 0. A steady level never sets it.
- R8: A set sticky status bit stays at 1 until software writes 0 to it. Writing 1 to it, or the pin returning to its earlier level, leaves it set.
- R9: If a qualifying sticky edge and a software clear of the same bit land in the same cycle, the bit stays set.
- R10: `slot_bits[i]` equals status bit i for input pins and is 0 for output pins. An input pin never has `pin_oe` asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (cold reset / power-up) |
| modem_rst | input | 1 | Synchronous reset of all four registers to their defaults |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register index |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data of the indexed register |
| pin_in | input | 10 | Raw pin inputs |
| pin_out | output | 10 | Pin output values |
| pin_oe | output | 10 | Pin output enables |
| slot_bits | output | 10 | Conditioned input status for the frame formatter |

## Verification
A sticky edge and a software clear of the same status bit can fall in one cycle. The bench provokes this by counting clock edges: it raises a sticky pin, then lines up a write of zero to the status register with the edge where the synchronised edge becomes visible. The bit must read 1 after that write. A later clear with no edge must then bring it to 0, which shows the clear path itself works.

// File: rtl/gpio_bank.sv
module gpio_bank #(
  parameter int N       = 10,
  parameter int DW      = 16,
  parameter int AW      = 8,
  parameter logic [AW-1:0] A_DIR = 8'h4C,
  parameter logic [AW-1:0] A_POL = 8'h4E,
  parameter logic [AW-1:0] A_STK = 8'h50,
  parameter logic [AW-1:0] A_STS = 8'h54
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          modem_rst,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [N-1:0]  pin_in,
  output logic [N-1:0]  pin_out,
  output logic [N-1:0]  pin_oe,
  output logic [N-1:0]  slot_bits
);
  localparam int PAD = DW - N;

  logic [N-1:0] dir, pol, stk, sts, sts_n;
  logic [N-1:0] s1, s2, prev;
  logic [N-1:0] cond, ev, clr, wv;
  logic         sts_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1   <= '0;
      s2   <= '0;
      prev <= '0;
    end else begin
      s1   <= pin_in;
      s2   <= s1;
      prev <= s2;
    end
  end

  assign wv     = wdata[N-1:0];
  assign sts_wr = wr_en && (addr == A_STS);
  assign clr    = sts_wr ? ~wv : '0;
  assign cond   = ~(s2 ^ pol);
  assign ev     = (pol & s2 & ~prev) | (~pol & ~s2 & prev);

  assign sts_n = (~dir & (sts_wr ? wv : sts))
               | (dir & ~stk & cond)
               | (dir & stk & (ev | (sts & ~clr)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir <= '1;
      pol <= '1;
      stk <= '0;
      sts <= '0;
    end else if (modem_rst) begin
      dir <= '1;
      pol <= '1;
      stk <= '0;
      sts <= '0;
    end else begin
      if (wr_en && addr == A_DIR) dir <= wv;
      if (wr_en && addr == A_POL) pol <= wv;
      if (wr_en && addr == A_STK) stk <= wv;
      sts <= sts_n;
    end
  end

  always_comb begin
    case (addr)
      A_DIR:   rdata = {{PAD{1'b0}}, dir};
      A_POL:   rdata = {{PAD{1'b1}}, pol};
      A_STK:   rdata = {{PAD{1'b0}}, stk};
      A_STS:   rdata = {{PAD{1'b0}}, sts};
      default: rdata = '0;
    endcase
  end

  assign pin_oe    = ~dir & (~pol | ~sts);
  assign pin_out   = ~dir & ~pol & sts;
  assign slot_bits = dir & sts;

  assert_sticky_hold_R8: assert property (@(posedge clk) disable iff (!rst_n || modem_rst)
    (!wr_en && !modem_rst) |=> (($past(sts) & $past(stk) & $past(dir) & ~sts) == '0));

  assert_modem_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    modem_rst |=> (dir == '1 && stk == '0 && sts == '0));

  assert_input_undriven_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & dir) == '0);

  assert_slot_inputs_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_bits & ~dir) == '0);

  assert_od_never_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & pin_out & pol) == '0);
endmodule

// File: tb/tb_gpio_bank.sv
module tb_gpio_bank;
  logic        clk = 0, rst_n = 0, modem_rst = 0, wr_en = 0;
  logic [7:0]  addr = 0;
  logic [15:0] wdata = 0, rdata;
  logic [9:0]  pin_in = 0, pin_out, pin_oe, slot_bits;
  int compared = 0, mismatched = 0;

  gpio_bank dut (.clk, .rst_n, .modem_rst, .wr_en, .addr, .wdata, .rdata,
                 .pin_in, .pin_out, .pin_oe, .slot_bits);

  always #2.5 clk = ~clk;

  task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [15:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic waitn(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [15:0] d;
    rd(8'h4C, d); chk("R1 dir reset", d, 16'h03FF);
    rd(8'h4E, d); chk("R3 pol reset", d, 16'hFFFF);
    rd(8'h50, d); chk("R2 stk reset", d, 16'h0000);
    rd(8'h54, d); chk("R2 sts reset", d, 16'h0000);
    chk("R10 oe reset", {6'b0, pin_oe}, 16'h0);
  endtask

  task automatic t_output;
    logic [15:0] d;
    wr(8'h4C, 16'hFFFE);
    rd(8'h4C, d); chk("R1 dir upper zero", d, 16'h03FE);
    wr(8'h4E, 16'h03FE);
    rd(8'h4E, d); chk("R3 pol upper one", d, 16'hFFFE);
    wr(8'h54, 16'h0001); waitn(1);
    chk("R4 pp oe", {15'b0, pin_oe[0]}, 16'h1);
    chk("R4 pp out hi", {15'b0, pin_out[0]}, 16'h1);
    chk("R10 slot output zero", {15'b0, slot_bits[0]}, 16'h0);
    wr(8'h54, 16'h0000); waitn(1);
    chk("R4 pp out lo", {14'b0, pin_oe[0], pin_out[0]}, 16'h2);
    wr(8'h4E, 16'h03FF);
    wr(8'h54, 16'h0001); waitn(1);
    chk("R5 od release", {14'b0, pin_oe[0], pin_out[0]}, 16'h0);
    wr(8'h54, 16'h0000); waitn(1);
    chk("R5 od drive low", {14'b0, pin_oe[0], pin_out[0]}, 16'h2);
    wr(8'h4C, 16'h03FF); waitn(1);
    chk("R10 input undriven", {6'b0, pin_oe}, 16'h0);
  endtask

  task automatic t_level;
    logic [15:0] d;
    pin_in[0] = 1; waitn(4);
    rd(8'h54, d); chk("R6 level active high", d, 16'h0001);
    chk("R10 slot follows", {6'b0, slot_bits}, 16'h0001);
    wr(8'h4E, 16'h03FE); waitn(1);
    rd(8'h54, d); chk("R6 level active low", d, 16'h0000);
    wr(8'h54, 16'h03FF); waitn(1);
    rd(8'h54, d); chk("R6 write ignored", d, 16'h0000);
    wr(8'h4E, 16'hFFFF);
    pin_in[0] = 0; waitn(4);
  endtask

  task automatic t_sticky;
    logic [15:0] d;
    wr(8'h50, 16'h0004);
    pin_in[2] = 1; waitn(4);
    rd(8'h54, d); chk("R7 rising sets", d, 16'h0004);
    pin_in[2] = 0; waitn(4);
    rd(8'h54, d); chk("R8 held after level drop", d, 16'h0004);
    wr(8'h54, 16'hFFFF); waitn(1);
    rd(8'h54, d); chk("R8 write one no effect", d, 16'h0004);
    wr(8'h54, 16'h0000); waitn(1);
    rd(8'h54, d); chk("R8 clear by zero", d, 16'h0000);
    pin_in[2] = 1; waitn(4);
    wr(8'h54, 16'h0000); waitn(4);
    rd(8'h54, d); chk("R7 level does not set", d, 16'h0000);
    wr(8'h4E, 16'h03FB); waitn(2);
    rd(8'h54, d); chk("R7 no set on pol change", d, 16'h0000);
    pin_in[2] = 0; waitn(4);
    rd(8'h54, d); chk("R7 falling sets", d, 16'h0004);
    wr(8'h54, 16'h0000);
    wr(8'h4E, 16'hFFFF);
  endtask

  task automatic t_coincide;
    logic [15:0] d;
    @(negedge clk); pin_in[2] = 1;
    @(negedge clk);
    @(negedge clk); wr_en = 1; addr = 8'h54; wdata = 16'h0000;
    @(negedge clk); wr_en = 0;
    rd(8'h54, d); chk("R9 edge beats clear", d, 16'h0004);
    wr(8'h54, 16'h0000); waitn(1);
    rd(8'h54, d); chk("R9 later clear works", d, 16'h0000);
    pin_in[2] = 0; waitn(4);
  endtask

  task automatic t_modem;
    logic [15:0] d;
    wr(8'h4C, 16'h0000);
    wr(8'h4E, 16'h0000);
    wr(8'h50, 16'h03FF);
    @(negedge clk); modem_rst = 1;
    @(negedge clk); modem_rst = 0;
    rd(8'h4C, d); chk("R2 dir default", d, 16'h03FF);
    rd(8'h4E, d); chk("R2 pol default", d, 16'hFFFF);
    rd(8'h50, d); chk("R2 stk default", d, 16'h0000);
    rd(8'h54, d); chk("R2 sts default", d, 16'h0000);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset;
        t_output;
        t_level;
        t_sticky;
        t_coincide;
        t_modem;
      end
      begin
        repeat (20000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule